// File: doc/BRIEF.md
# Programmable Pausable Local Clock Generator

This block is a cycle-level model of the clock source for one locally synchronous island. A fast reference clock takes the place of an analog delay line. The block emits a one-cycle clock-enable pulse on `lclk_en_o`. The spacing between pulses is a whole number of reference ticks, set by a coarse code and a fine code. Both codes can be changed after fabrication, so one generator design can serve islands with different critical paths. The fine range covers at least one coarse step, so no period inside the span is out of reach.

A secure mode picks a new coarse code for every local cycle. The code comes from a 16-bit linear feedback shift register and is clamped into a programmable code window. This makes the island's timing hard to predict.

Port controllers stop the clock by raising a pause request. An arbiter grants one request at a time, and only between pulses, so a pulse and a grant never overlap. The clock stays stopped until the owning port drops its request. In test mode the pulse output follows an external synchronous tick so that the island can be scan tested. A small register port sets the codes and reads back the effective code, the pause state, the grant owner and a saturating pulse count.

Top module: `pausable_clkgen`

## Requirements
- R1: The interval between pulses is MIN_TICKS + coarse*COARSE_TICKS + fine reference cycles. Each pulse is high for one cycle. After reset (coarse 0, fine 0, MIN_TICKS 4) the first pulse appears on the 4th rising edge after reset is released.
- R2: A write to the coarse or fine code does not disturb the running interval. The new value sets the interval that starts at the next pulse. A write on the same edge as a pulse is not used for that reload.
- R3: With secure mode set (bit 8 of register 0), each reload takes bits 3:0 of the shift register as the coarse code. That code is clamped first to the window high code and then to the window low code (register 1: low in bits 3:0, high in bits 7:4). The shift register advances once per pulse, and only in secure mode.
- R4: The shift register shifts left, and its new bit 0 is the XOR of bits 15, 13, 12 and 10. It resets to 0xACE1. A write to register 2 loads the written value, except that 0 loads 1. Register 2 reads back the current shift register value.
- R5: With no grant held, a raised pause request is granted on the next edge that emits no pulse and is not in test mode. The lowest-numbered raised request wins. While a grant is held, no pulse is emitted and the interval counter holds its value.
- R6: A grant is held while its owner's request stays high. It is released on the first edge that sees that request low, and generation resumes from the held count. Other requests wait for that release.
- R7: While the test input is high, `lclk_en_o` equals `ext_tick_i`, internal generation is frozen, and no new grant is issued.
- R8: Register 3 reads the effective coarse code of the running interval in bits 3:0, the pause-active flag in bit 4, and the grant owner index in bits 6:5 (0 when no grant is held).
- R9: Register 4 reads the number of internally generated pulses. The count saturates at its maximum value (255 with an 8-bit counter).
- R10: Register 0 reads coarse in bits 3:0, fine in bits 7:4 and secure in bit 8. After reset, register 0 reads 0 and register 1 reads 0x00F0. Reads from any address above 4 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| test_mode_i | input | 1 | Selects the external tick in place of the generated pulse |
| ext_tick_i | input | 1 | External synchronous tick used in test mode |
| pause_req_i | input | NPORT | One pause request per port controller |
| pause_gnt_o | output | NPORT | One-hot pause grant |
| lclk_en_o | output | 1 | Local clock-enable pulse for the island |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register address for write and read |
| cfg_wdata_i | input | DATA_W | Register write data |
| cfg_rdata_o | output | DATA_W | Register read data for `cfg_addr_i` |

## Verification
Two functions can land on the same reference edge. The first is the counter running out, which emits a pulse and reloads the interval. The second is a pause request, or a configuration or seed write. On that edge the pulse must win over the grant, and the reload must use the register values from before the edge. The bench toggles requests and issues writes at random, so these coincidences occur many times. A bench reference model of the requirements judges every cycle: the pulse output, the grant vector and the read-back register. Directed cases cover a two-way request tie, a zero seed and counter saturation.

// File: rtl/lcg_pkg.sv
package lcg_pkg;

   typedef enum logic [2:0] {
      REG_CTRL = 3'd0,
      REG_WIN  = 3'd1,
      REG_SEED = 3'd2,
      REG_STAT = 3'd3,
      REG_CNT  = 3'd4
   } reg_addr_e;

   localparam logic [15:0] LFSR_RESET = 16'hACE1;
   localparam logic [15:0] LFSR_TAPS  = 16'hB400;

endpackage

// File: rtl/lcg_lfsr.sv
module lcg_lfsr #(
   parameter int          W        = 16,
   parameter logic [W-1:0] TAPS    = W'(16'hB400),
   parameter logic [W-1:0] RST_VAL = W'(16'hACE1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] state
);

   if (W < 2) begin : g_bad_width
      $error("lcg_lfsr: W must be at least 2");
   end

   logic fb;
   assign fb = ^(state & TAPS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= RST_VAL;
      end else if (load) begin
         state <= (load_val == '0) ? W'(1) : load_val;
      end else if (adv) begin
         state <= {state[W-2:0], fb};
      end
   end

endmodule

// File: rtl/lcg_arbiter.sv
module lcg_arbiter #(
   parameter int NPORT = 4,
   parameter int OWN_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPORT-1:0] req,
   input  logic             allow,
   output logic [NPORT-1:0] gnt,
   output logic [OWN_W-1:0] owner
);

   logic [NPORT-1:0] pick;

   if (NPORT == 1) begin : g_single
      assign pick = req;
   end else begin : g_multi
      localparam logic [NPORT-1:0] ONE = NPORT'(1);
      always_comb begin
         pick = '0;
         for (int i = NPORT - 1; i >= 0; i--) begin
            if (req[i]) pick = ONE << i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt <= '0;
      end else if (gnt == '0) begin
         if (allow && (req != '0)) gnt <= pick;
      end else if ((gnt & req) == '0) begin
         gnt <= '0;
      end
   end

   always_comb begin
      owner = '0;
      for (int i = 0; i < NPORT; i++) begin
         if (gnt[i]) owner = OWN_W'(i);
      end
   end

endmodule

// File: rtl/lcg_period_gen.sv
module lcg_period_gen #(
   parameter int CODE_W       = 4,
   parameter int PER_W        = 7,
   parameter int CNT_W        = 16,
   parameter int MIN_TICKS    = 4,
   parameter int COARSE_TICKS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [CODE_W-1:0] next_code,
   input  logic [CODE_W-1:0] fine,
   output logic              fire,
   output logic              tick,
   output logic [CODE_W-1:0] eff_code,
   output logic [CNT_W-1:0]  pulse_cnt
);

   logic [PER_W-1:0] cnt;
   logic [PER_W-1:0] reload;

   assign reload = PER_W'(MIN_TICKS) + PER_W'(next_code) * PER_W'(COARSE_TICKS)
                 + PER_W'(fine) - PER_W'(1);
   assign fire   = run && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= PER_W'(MIN_TICKS - 1);
         tick      <= 1'b0;
         eff_code  <= '0;
         pulse_cnt <= '0;
      end else begin
         tick <= fire;
         if (fire) begin
            cnt      <= reload;
            eff_code <= next_code;
            if (pulse_cnt != '1) pulse_cnt <= pulse_cnt + CNT_W'(1);
         end else if (run) begin
            cnt <= cnt - PER_W'(1);
         end
      end
   end

endmodule

// File: rtl/lcg_cfg_regs.sv
module lcg_cfg_regs
   import lcg_pkg::*;
#(
   parameter int CODE_W = 4,
   parameter int DATA_W = 16,
   parameter int LFSR_W = 16,
   parameter int OWN_W  = 2,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [2:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CODE_W-1:0] eff_code,
   input  logic              paused,
   input  logic [OWN_W-1:0]  owner,
   input  logic [CNT_W-1:0]  pulse_cnt,
   input  logic [LFSR_W-1:0] lfsr_q,
   output logic [CODE_W-1:0] coarse,
   output logic [CODE_W-1:0] fine,
   output logic              sec_mode,
   output logic [CODE_W-1:0] win_lo,
   output logic [CODE_W-1:0] win_hi,
   output logic              seed_we,
   output logic [LFSR_W-1:0] seed_val,
   output logic [DATA_W-1:0] rdata
);

   localparam int CTRL_W = 2 * CODE_W + 1;
   localparam int STAT_W = CODE_W + 1 + OWN_W;

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   assign seed_we  = we && (addr == REG_SEED);
   assign seed_val = wdata[LFSR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coarse   <= '0;
         fine     <= '0;
         sec_mode <= 1'b0;
         win_lo   <= '0;
         win_hi   <= '1;
      end else if (we) begin
         if (addr == REG_CTRL) begin
            coarse   <= wdata[CODE_W-1:0];
            fine     <= wdata[2*CODE_W-1:CODE_W];
            sec_mode <= wdata[2*CODE_W];
         end
         if (addr == REG_WIN) begin
            win_lo <= wdata[CODE_W-1:0];
            win_hi <= wdata[2*CODE_W-1:CODE_W];
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         REG_CTRL: rdata[CTRL_W-1:0]   = {sec_mode, fine, coarse};
         REG_WIN:  rdata[2*CODE_W-1:0] = {win_hi, win_lo};
         REG_SEED: rdata[LFSR_W-1:0]   = lfsr_q;
         REG_STAT: rdata[STAT_W-1:0]   = {owner, paused, eff_code};
         REG_CNT:  rdata[CNT_W-1:0]    = pulse_cnt;
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/pausable_clkgen.sv
module pausable_clkgen
   import lcg_pkg::*;
#(
   parameter int NPORT        = 4,
   parameter int CODE_W       = 4,
   parameter int MIN_TICKS    = 4,
   parameter int COARSE_TICKS = 4,
   parameter int CNT_W        = 16,
   parameter int DATA_W       = 16,
   parameter int LFSR_W       = 16,
   parameter bit HAS_SECURE   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              test_mode_i,
   input  logic              ext_tick_i,
   input  logic [NPORT-1:0]  pause_req_i,
   output logic [NPORT-1:0]  pause_gnt_o,
   output logic              lclk_en_o,
   input  logic              cfg_we_i,
   input  logic [2:0]        cfg_addr_i,
   input  logic [DATA_W-1:0] cfg_wdata_i,
   output logic [DATA_W-1:0] cfg_rdata_o
);

   localparam int CODE_MAX = (2 ** CODE_W) - 1;
   localparam int MAX_PER  = MIN_TICKS + CODE_MAX * COARSE_TICKS + CODE_MAX;
   localparam int PER_W    = $clog2(MAX_PER + 1);
   localparam int OWN_W    = (NPORT > 1) ? $clog2(NPORT) : 1;

   if (MIN_TICKS < 2) begin : g_bad_min
      $error("pausable_clkgen: MIN_TICKS must be at least 2");
   end
   if (CODE_MAX < COARSE_TICKS) begin : g_bad_fine
      $error("pausable_clkgen: fine range must cover one coarse step");
   end
   if (NPORT < 1 || NPORT > 8) begin : g_bad_nport
      $error("pausable_clkgen: NPORT must be 1 to 8");
   end
   if (CNT_W > DATA_W || LFSR_W > DATA_W || 2 * CODE_W + 1 > DATA_W) begin : g_bad_data
      $error("pausable_clkgen: DATA_W too narrow for the register fields");
   end
   if (CODE_W + 1 + OWN_W > DATA_W) begin : g_bad_stat
      $error("pausable_clkgen: DATA_W too narrow for status");
   end

   logic [CODE_W-1:0] coarse, fine, win_lo, win_hi, eff_code, next_code;
   logic              sec_mode, seed_we, fire, tick_q, run, allow;
   logic [LFSR_W-1:0] seed_val, lfsr_q;
   logic [OWN_W-1:0]  owner;
   logic [CNT_W-1:0]  pulse_cnt;

   assign run   = !test_mode_i && (pause_gnt_o == '0);
   assign allow = !test_mode_i && !fire;

   if (HAS_SECURE) begin : g_secure
      logic [CODE_W-1:0] raw, capped;

      lcg_lfsr #(
         .W       (LFSR_W),
         .TAPS    (LFSR_W'(LFSR_TAPS)),
         .RST_VAL (LFSR_W'(LFSR_RESET))
      ) u_lfsr (
         .clk      (clk),
         .rst_n    (rst_n),
         .adv      (fire && sec_mode),
         .load     (seed_we),
         .load_val (seed_val),
         .state    (lfsr_q)
      );

      assign raw       = lfsr_q[CODE_W-1:0];
      assign capped    = (raw > win_hi) ? win_hi : raw;
      assign next_code = !sec_mode ? coarse : ((capped < win_lo) ? win_lo : capped);
   end else begin : g_plain
      logic unused_sec;
      assign unused_sec = ^{sec_mode, seed_we, seed_val, win_lo, win_hi};
      assign lfsr_q     = '0;
      assign next_code  = coarse;
   end

   lcg_period_gen #(
      .CODE_W       (CODE_W),
      .PER_W        (PER_W),
      .CNT_W        (CNT_W),
      .MIN_TICKS    (MIN_TICKS),
      .COARSE_TICKS (COARSE_TICKS)
   ) u_period (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .next_code (next_code),
      .fine      (fine),
      .fire      (fire),
      .tick      (tick_q),
      .eff_code  (eff_code),
      .pulse_cnt (pulse_cnt)
   );

   lcg_arbiter #(
      .NPORT (NPORT),
      .OWN_W (OWN_W)
   ) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (pause_req_i),
      .allow (allow),
      .gnt   (pause_gnt_o),
      .owner (owner)
   );

   lcg_cfg_regs #(
      .CODE_W (CODE_W),
      .DATA_W (DATA_W),
      .LFSR_W (LFSR_W),
      .OWN_W  (OWN_W),
      .CNT_W  (CNT_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we_i),
      .addr      (cfg_addr_i),
      .wdata     (cfg_wdata_i),
      .eff_code  (eff_code),
      .paused    (pause_gnt_o != '0),
      .owner     (owner),
      .pulse_cnt (pulse_cnt),
      .lfsr_q    (lfsr_q),
      .coarse    (coarse),
      .fine      (fine),
      .sec_mode  (sec_mode),
      .win_lo    (win_lo),
      .win_hi    (win_hi),
      .seed_we   (seed_we),
      .seed_val  (seed_val),
      .rdata     (cfg_rdata_o)
   );

   assign lclk_en_o = test_mode_i ? ext_tick_i : tick_q;

endmodule

// File: rtl/pausable_clkgen_chk.sv
module pausable_clkgen_chk #(
   parameter int NPORT  = 4,
   parameter int CODE_W = 4,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              test_mode_i,
   input logic              tick_q,
   input logic [NPORT-1:0]  pause_req_i,
   input logic [NPORT-1:0]  pause_gnt_o,
   input logic [CNT_W-1:0]  pulse_cnt,
   input logic [CODE_W-1:0] eff_code,
   input logic [CODE_W-1:0] win_lo,
   input logic [CODE_W-1:0] win_hi,
   input logic              sec_mode
);

   logic seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   // R1
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q |=> !tick_q);

   // R5
   pulse_vs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q |-> (pause_gnt_o == '0));

   // R5
   single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pause_gnt_o));

   // R5
   grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && pause_gnt_o != '0 && $past(pause_gnt_o) == '0)
         |-> (($past(pause_req_i) & pause_gnt_o) != '0));

   // R6
   grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pause_gnt_o & pause_req_i) != '0) |=> (pause_gnt_o == $past(pause_gnt_o)));

   // R7
   no_test_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && pause_gnt_o != '0 && $past(pause_gnt_o) == '0) |-> !$past(test_mode_i));

   // R3
   rand_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && tick_q && $past(sec_mode) && ($past(win_lo) <= $past(win_hi)))
         |-> (eff_code >= $past(win_lo) && eff_code <= $past(win_hi)));

   // R9
   count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> (pulse_cnt >= $past(pulse_cnt)));

endmodule

bind pausable_clkgen pausable_clkgen_chk #(
   .NPORT  (NPORT),
   .CODE_W (CODE_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .test_mode_i (test_mode_i),
   .tick_q      (tick_q),
   .pause_req_i (pause_req_i),
   .pause_gnt_o (pause_gnt_o),
   .pulse_cnt   (pulse_cnt),
   .eff_code    (eff_code),
   .win_lo      (win_lo),
   .win_hi      (win_hi),
   .sec_mode    (sec_mode)
);

// File: tb/pausable_clkgen_tb.sv
`timescale 1ns/1ps
module pausable_clkgen_tb;

   localparam int NP = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        test_mode = 1'b0;
   logic        ext_tick = 1'b0;
   logic [NP-1:0] req = '0;
   logic [NP-1:0] gnt;
   logic        lclk_en;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = 3'd0;
   logic [15:0] cfg_wdata = 16'h0;
   logic [15:0] cfg_rdata;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pausable_clkgen #(.NPORT(NP), .CNT_W(8)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .test_mode_i (test_mode),
      .ext_tick_i  (ext_tick),
      .pause_req_i (req),
      .pause_gnt_o (gnt),
      .lclk_en_o   (lclk_en),
      .cfg_we_i    (cfg_we),
      .cfg_addr_i  (cfg_addr),
      .cfg_wdata_i (cfg_wdata),
      .cfg_rdata_o (cfg_rdata)
   );

   // reference model state
   int          m_cnt;
   logic        m_tick;
   logic [NP-1:0] m_gnt;
   logic [15:0] m_lfsr;
   logic [3:0]  m_eff, m_coarse, m_fine, m_lo, m_hi;
   logic        m_sec;
   int          m_count;

   function automatic logic [3:0] f_clamp(input logic [3:0] r, input logic [3:0] lo, input logic [3:0] hi);
      logic [3:0] x;
      x = (r > hi) ? hi : r;
      return (x < lo) ? lo : x;
   endfunction

   function automatic logic [15:0] f_step(input logic [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   function automatic int f_period(input logic [3:0] c, input logic [3:0] f);
      return 4 + 4 * int'(c) + int'(f);
   endfunction

   function automatic logic [NP-1:0] f_lowest(input logic [NP-1:0] r);
      for (int i = 0; i < NP; i++) if (r[i]) return NP'(1) << i;
      return '0;
   endfunction

   function automatic logic [1:0] f_idx(input logic [NP-1:0] g);
      for (int i = 0; i < NP; i++) if (g[i]) return 2'(i);
      return 2'd0;
   endfunction

   function automatic logic [15:0] f_rd(input logic [2:0] a);
      case (a)
         3'd0: return {7'b0, m_sec, m_fine, m_coarse};
         3'd1: return {8'b0, m_hi, m_lo};
         3'd2: return m_lfsr;
         3'd3: return {9'b0, f_idx(m_gnt), (m_gnt != '0), m_eff};
         3'd4: return 16'(m_count);
         default: return 16'h0;
      endcase
   endfunction

   function automatic string f_tag(input logic [2:0] a);
      case (a)
         3'd2: return "R4";
         3'd3: return "R8";
         3'd4: return "R9";
         default: return "R10";
      endcase
   endfunction

   always @(posedge clk) begin : model
      logic run, pnow;
      logic [3:0] code;
      if (!rst_n) begin
         m_cnt <= 3; m_tick <= 1'b0; m_gnt <= '0; m_lfsr <= 16'hACE1;
         m_eff <= 4'd0; m_count <= 0; m_coarse <= 4'd0; m_fine <= 4'd0;
         m_sec <= 1'b0; m_lo <= 4'd0; m_hi <= 4'hF;
      end else begin
         run  = !test_mode && (m_gnt == '0);
         pnow = run && (m_cnt == 0);
         code = m_sec ? f_clamp(m_lfsr[3:0], m_lo, m_hi) : m_coarse;
         m_tick <= pnow;
         if (pnow) begin
            m_cnt <= f_period(code, m_fine) - 1;
            m_eff <= code;
            if (m_count != 255) m_count <= m_count + 1;
            if (m_sec) m_lfsr <= f_step(m_lfsr);
         end else if (run) begin
            m_cnt <= m_cnt - 1;
         end
         if (m_gnt == '0) begin
            if (req != '0 && !test_mode && !pnow) m_gnt <= f_lowest(req);
         end else if ((m_gnt & req) == '0) begin
            m_gnt <= '0;
         end
         if (cfg_we) begin
            case (cfg_addr)
               3'd0: begin m_coarse <= cfg_wdata[3:0]; m_fine <= cfg_wdata[7:4]; m_sec <= cfg_wdata[8]; end
               3'd1: begin m_lo <= cfg_wdata[3:0]; m_hi <= cfg_wdata[7:4]; end
               3'd2: m_lfsr <= (cfg_wdata == 16'h0) ? 16'h0001 : cfg_wdata;
               default: ;
            endcase
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      check(test_mode ? "R7" : (m_sec ? "R3" : "R1"), 32'(lclk_en), 32'(test_mode ? ext_tick : m_tick));
      check("R5", 32'(gnt), 32'(m_gnt));
      check(f_tag(cfg_addr), 32'(cfg_rdata), 32'(f_rd(cfg_addr)));
   endtask

   task automatic cyc();
      @(negedge clk);
      compare_all();
   endtask

   task automatic cfg_write(input logic [2:0] a, input logic [15:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      cyc();
      cfg_we = 1'b0;
   endtask

   task automatic wait_pulse();
      int g = 0;
      do begin cyc(); g++; end while (lclk_en !== 1'b1 && g < 300);
   endtask

   task automatic measure(output int n);
      n = 0;
      do begin cyc(); n++; end while (lclk_en !== 1'b1 && n < 300);
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      int n;
      int pulses;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // reset state
      cfg_addr = 3'd0; #1; check("R10", 32'(cfg_rdata), 32'h0);
      check("R1", 32'(lclk_en), 32'h0);
      check("R5", 32'(gnt), 32'h0);
      cfg_addr = 3'd1; #1; check("R10", 32'(cfg_rdata), 32'h00F0);
      cfg_addr = 3'd2; #1; check("R4", 32'(cfg_rdata), 32'hACE1);
      cfg_addr = 3'd3;
      rst_n = 1'b1;
      // R1: first pulse on the 4th edge after release, default period 4
      n = 0;
      do begin cyc(); n++; end while (lclk_en !== 1'b1 && n < 20);
      check("R1", 32'(n), 32'd4);
      measure(n); check("R1", 32'(n), 32'd4);
      // R2: new codes apply from the next pulse
      cfg_write(3'd0, 16'h0032);
      wait_pulse();
      measure(n); check("R2", 32'(n), 32'd15);
      measure(n); check("R2", 32'(n), 32'd15);
      // R5/R6: tie between ports 2 and 3
      cfg_addr = 3'd3;
      req = 4'b1100;
      n = 0;
      do begin cyc(); n++; end while (gnt == '0 && n < 40);
      check("R5", 32'(gnt), 32'b0100);
      pulses = 0;
      for (int i = 0; i < 30; i++) begin cyc(); if (lclk_en) pulses++; end
      check("R5", 32'(pulses), 32'd0);
      check("R8", 32'(cfg_rdata[6:4]), 32'b101);
      req = 4'b1000;
      cyc(); check("R6", 32'(gnt), 32'b0000);
      repeat (40) cyc();
      req = 4'b0000;
      repeat (40) cyc();
      // R4: seed handling
      cfg_write(3'd2, 16'h0000);
      cfg_addr = 3'd2; #1; check("R4", 32'(cfg_rdata), 32'h0001);
      cfg_write(3'd2, 16'h1234);
      #1; check("R4", 32'(cfg_rdata), 32'h1234);
      // R3: window 3..6 in secure mode
      cfg_write(3'd1, 16'h0063);
      cfg_write(3'd0, 16'h0100);
      wait_pulse();
      for (int i = 0; i < 20; i++) begin
         measure(n);
         check("R3", 32'((n >= 16) && (n <= 28)), 32'd1);
      end
      // R9: saturation at minimum period
      cfg_write(3'd0, 16'h0000);
      repeat (1100) cyc();
      cfg_addr = 3'd4;
      cyc(); check("R9", 32'(cfg_rdata), 32'd255);
      // R7: test mode passthrough
      test_mode = 1'b1;
      req = 4'b0001;
      for (int i = 0; i < 40; i++) begin ext_tick = ($urandom % 2) == 1; cyc(); end
      check("R7", 32'(gnt), 32'h0);
      test_mode = 1'b0;
      ext_tick = 1'b0;
      req = '0;
      repeat (20) cyc();
      // random mixed phase
      for (int i = 0; i < 8000; i++) begin
         for (int p = 0; p < NP; p++) if ($urandom % 24 == 0) req[p] = ~req[p];
         if ($urandom % 300 == 0) test_mode = ~test_mode;
         ext_tick = ($urandom % 2) == 1;
         cfg_we = ($urandom % 16) == 0;
         if (cfg_we) begin
            cfg_addr = 3'($urandom % 3);
            cfg_wdata = 16'($urandom);
            if (cfg_addr == 3'd2 && ($urandom % 4) == 0) cfg_wdata = 16'h0;
         end else begin
            cfg_addr = 3'($urandom % 6);
         end
         cyc();
      end
      cfg_we = 1'b0;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule